// File: doc/BRIEF.md
# Zero-Turnaround Synchronous Burst SRAM

This block is an on-chip synchronous memory whose command interface lets reads and writes follow each other in any order, one per clock, with no idle cycle when the bus direction changes. An address and command are taken on a rising clock edge. Write data follows the address later, after one enabled cycle in flow-through timing and after two in pipelined timing. Read data appears in the cycle after the command edge in flow-through timing, and one edge later in pipelined timing. A small write pipeline holds the address of each write until its data arrives. A read issued while that data is still on its way is answered with the arriving bytes merged over the stored word.

A load command starts a four-beat burst on the two low address bits. Advance commands then step through the burst in linear or interleaved order, and the order wraps back to the start beat on the fifth beat. There are three chip enables, a clock enable that freezes the whole block, per-byte active-low write enables on 9-bit bytes, an asynchronous output enable and a sleep input.

Top module: `zt_burst_sram`

## Requirements
- R1: After a synchronous active-low reset, `dout_oe` is 0 and `dout` is all zeros until a read produces data.
- R2: With `flow_n`=1 (pipelined), data for a read captured at enabled edge n is driven on `dout`, with `dout_oe`=1, after the next enabled edge.
- R3: With `flow_n`=0 (flow-through), data for a read captured at enabled edge n is driven on `dout` right after edge n.
- R4: In pipelined timing, write data is sampled from `din` at the second enabled edge after the write command edge. `din` at any other edge is not written.
- R5: In flow-through timing, write data is sampled from `din` at the first enabled edge after the write command edge.
- R6: A read may follow a write on the next cycle at the same address. It returns the newly written bytes, merged with the stored bytes that the write did not enable.
- R7: Bit b of `byte_we_n`, sampled with each write beat, is active low and enables `din[9b+8:9b]`. Any mix is allowed, from all bytes to none.
- R8: A load with `sel0_n`=1, `sel1`=0 or `sel2_n`=1 is a deselect. It starts no burst, writes nothing and drives no data.
- R9: With `seq_ilv`=0, beat k of a burst uses low address bits (start+k) mod 4, and the fifth beat returns to the start address.
- R10: With `seq_ilv`=1, beat k of a burst uses low address bits start XOR k, and the order also wraps on the fifth beat.
- R11: While `clk_en`=0, no command, address or data is taken and all state and outputs are held.
- R12: `oe_n`=1 forces `dout_oe` to 0 at once, whatever the read pipeline holds.
- R13: While `sleep`=1, `dout_oe` is 0 and commands and data on the pins are ignored.
- R14: Deselect and hold cycles do not discard write data still due. The write completes when its data edge arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_en | input | 1 | Clock enable; low makes the cycle a hold |
| sel0_n | input | 1 | Chip enable, active low |
| sel1 | input | 1 | Chip enable, active high |
| sel2_n | input | 1 | Chip enable, active low |
| load_n | input | 1 | Low: load a new command and address; high: advance the current burst |
| we_n | input | 1 | Low: write, high: read (used on load) |
| byte_we_n | input | NBYTES | Per-byte write enables, active low |
| addr | input | ADDR_W | Word address |
| din | input | NBYTES*BYTE_W | Write data, taken late |
| dout | output | NBYTES*BYTE_W | Read data, zero while not driven |
| dout_oe | output | 1 | Read data driven |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous sleep, active high |
| flow_n | input | 1 | Static timing select: 0 flow-through, 1 pipelined |
| seq_ilv | input | 1 | Static burst order: 0 linear, 1 interleaved |

## Verification
The bench sweeps all four combinations of timing and burst order. In each it fills and reads the whole small array with bursts that start at every low-address offset and run into the fifth, wrapping beat. A design that took write data one edge early or late would store the junk the bench drives on every non-data edge. A read placed directly after a write to the same address, under every byte-enable pattern, exposes a missing forward path as stale bytes. Hold, sleep, deselect and output-enable cycles are placed while write data is still due or read data is on the bus. A block that flushed its write pipeline, captured pins during a hold, or ignored a deselected chip enable would show a wrong word or a wrongly driven bus.

// File: rtl/zt_sram_pkg.sv
// Shared types and the burst-order helper for the zero-turnaround SRAM.
// Assumes the burst always spans the two low address bits.
package zt_sram_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } zt_op_e;

    // Low address bits of a burst beat: XOR order or modulo-4 add order.
    function automatic logic [1:0] beat_lo(input logic [1:0] start,
                                           input logic [1:0] beat,
                                           input logic       ilv);
        return ilv ? (start ^ beat) : (start + beat);
    endfunction

endpackage

// File: rtl/zt_burst_seq.sv
// Command capture and burst address generation.
// Takes a load or advance command on each enabled edge and presents the
// command in effect (operation, word address, byte enables) until the next
// enabled edge. Assumes ADDR_W >= 3 and a static burst-order input.
module zt_burst_seq
    import zt_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int NBYTES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              load_n,
    input  logic              we_n,
    input  logic              chips_ok,
    input  logic              ilv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NBYTES-1:0] byte_we_n,
    output zt_op_e            cmd_op,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [NBYTES-1:0] cmd_be
);

    localparam int HI_W = ADDR_W - 2;

    zt_op_e            op_q;
    logic [ADDR_W-1:0] base_q;
    logic [1:0]        beat_q;
    logic [NBYTES-1:0] be_q;

    // Capture a new command on load, or step the beat counter on advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_IDLE;
            base_q <= '0;
            beat_q <= '0;
            be_q   <= '0;
        end else if (step) begin
            be_q <= ~byte_we_n;
            if (!load_n) begin
                base_q <= addr;
                beat_q <= 2'd0;
                op_q   <= !chips_ok ? OP_IDLE : (we_n ? OP_READ : OP_WRITE);
            end else begin
                beat_q <= beat_q + 2'd1;
            end
        end
    end

    // Present the current beat address from the stored start address.
    always_comb begin
        cmd_addr = {base_q[ADDR_W-1 -: HI_W], beat_lo(base_q[1:0], beat_q, ilv)};
        cmd_op   = op_q;
        cmd_be   = be_q;
    end

    assert_hold_freezes_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> ($stable(op_q) && $stable(base_q) && $stable(beat_q)));

    assert_desel_no_op_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load_n && !chips_ok) |=> (cmd_op == OP_IDLE));

    assert_beat_steps_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (step && load_n) |=> (beat_q == $past(beat_q) + 2'd1));

endmodule

// File: rtl/zt_late_write.sv
// Late-write pipeline.
// Holds the address and byte enables of each write until its data edge.
// Flow-through timing commits the command in effect at the next enabled
// edge; pipelined timing delays it by one further enabled edge. Only enabled
// edges move the pipeline, so holds and deselects keep pending writes.
module zt_late_write
    import zt_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int NBYTES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              flow_n,
    input  zt_op_e            cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [NBYTES-1:0] cmd_be,
    output logic              cmt_valid,
    output logic [ADDR_W-1:0] cmt_addr,
    output logic [NBYTES-1:0] cmt_be
);

    logic              stg_v;
    logic [ADDR_W-1:0] stg_addr;
    logic [NBYTES-1:0] stg_be;

    // Extra stage that gives pipelined timing its second late cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_v    <= 1'b0;
            stg_addr <= '0;
            stg_be   <= '0;
        end else if (step) begin
            stg_v    <= (cmd_op == OP_WRITE);
            stg_addr <= cmd_addr;
            stg_be   <= cmd_be;
        end
    end

    // Choose which write takes din at the coming enabled edge.
    always_comb begin
        if (!flow_n) begin
            cmt_valid = (cmd_op == OP_WRITE);
            cmt_addr  = cmd_addr;
            cmt_be    = cmd_be;
        end else begin
            cmt_valid = stg_v;
            cmt_addr  = stg_addr;
            cmt_be    = stg_be;
        end
    end

    assert_double_late_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && flow_n && cmd_op == OP_WRITE) |=> (stg_v && stg_addr == $past(cmd_addr)));

endmodule

// File: rtl/zt_mem_array.sv
// Byte-writable storage with one combinational read port.
// The read port forwards the bytes being written in this cycle when the
// addresses match, so a read sees a write whose data is arriving now.
module zt_mem_array #(
    parameter int ADDR_W = 6,
    parameter int NBYTES = 2,
    parameter int BYTE_W = 9
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [NBYTES-1:0]        wr_be,
    input  logic [NBYTES*BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [NBYTES*BYTE_W-1:0] rd_data
);

    localparam int DEPTH  = 1 << ADDR_W;
    localparam int DATA_W = NBYTES * BYTE_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] stored;
    logic              hit;

    // Write the enabled bytes of the committing word.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int b = 0; b < NBYTES; b++) begin
                if (wr_be[b]) mem[wr_addr][b*BYTE_W +: BYTE_W] <= wr_data[b*BYTE_W +: BYTE_W];
            end
        end
    end

    // Look up the stored word and detect a same-address commit.
    always_comb begin
        stored = mem[rd_addr];
        hit    = wr_en && (wr_addr == rd_addr);
    end

    for (genvar g = 0; g < NBYTES; g++) begin : g_fwd
        // Per byte: take the arriving byte if it is written now, else the stored one.
        always_comb begin
            rd_data[g*BYTE_W +: BYTE_W] = (hit && wr_be[g]) ? wr_data[g*BYTE_W +: BYTE_W]
                                                            : stored[g*BYTE_W +: BYTE_W];
        end
    end

endmodule

// File: rtl/zt_burst_sram.sv
// Zero-turnaround synchronous burst SRAM, top level.
// Joins command capture, the late-write pipeline and the storage, and
// builds the read path in flow-through or pipelined timing. flow_n and
// seq_ilv are assumed static; oe_n and sleep act on the output at once.
// Sleep also blocks every enabled edge, so it ignores pins like a hold.
module zt_burst_sram
    import zt_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int NBYTES = 2,
    parameter int BYTE_W = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clk_en,
    input  logic                     sel0_n,
    input  logic                     sel1,
    input  logic                     sel2_n,
    input  logic                     load_n,
    input  logic                     we_n,
    input  logic [NBYTES-1:0]        byte_we_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [NBYTES*BYTE_W-1:0] din,
    output logic [NBYTES*BYTE_W-1:0] dout,
    output logic                     dout_oe,
    input  logic                     oe_n,
    input  logic                     sleep,
    input  logic                     flow_n,
    input  logic                     seq_ilv
);

    localparam int DATA_W = NBYTES * BYTE_W;

    logic              step;
    logic              chips_ok;
    zt_op_e            cmd_op;
    logic [ADDR_W-1:0] cmd_addr;
    logic [NBYTES-1:0] cmd_be;
    logic              cmt_valid;
    logic [ADDR_W-1:0] cmt_addr;
    logic [NBYTES-1:0] cmt_be;
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] pipe_q;
    logic              pipe_v;
    logic [DATA_W-1:0] out_word;
    logic              out_v;

    // Qualify edges and combine the three chip enables.
    always_comb begin
        step     = clk_en && !sleep;
        chips_ok = !sel0_n && sel1 && !sel2_n;
    end

    zt_burst_seq #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .load_n    (load_n),
        .we_n      (we_n),
        .chips_ok  (chips_ok),
        .ilv       (seq_ilv),
        .addr      (addr),
        .byte_we_n (byte_we_n),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr),
        .cmd_be    (cmd_be)
    );

    zt_late_write #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) wpipe_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .flow_n    (flow_n),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr),
        .cmd_be    (cmd_be),
        .cmt_valid (cmt_valid),
        .cmt_addr  (cmt_addr),
        .cmt_be    (cmt_be)
    );

    zt_mem_array #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) mem_i (
        .clk     (clk),
        .wr_en   (step && cmt_valid),
        .wr_addr (cmt_addr),
        .wr_be   (cmt_be),
        .wr_data (din),
        .rd_addr (cmd_addr),
        .rd_data (rd_word)
    );

    // Output register used by pipelined timing; loads on enabled edges only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_v <= 1'b0;
            pipe_q <= '0;
        end else if (step) begin
            pipe_v <= (cmd_op == OP_READ);
            pipe_q <= rd_word;
        end
    end

    // Pick the timing variant and apply the asynchronous output controls.
    always_comb begin
        out_v    = flow_n ? pipe_v : (cmd_op == OP_READ);
        out_word = flow_n ? pipe_q : rd_word;
        dout_oe  = out_v && !oe_n && !sleep;
        dout     = dout_oe ? out_word : '0;
    end

    assert_pipe_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && flow_n && cmd_op == OP_READ) |=> pipe_v);

endmodule

// File: tb/zt_burst_sram_tb_top.sv
// Self-checking sweep over timing mode and burst order for zt_burst_sram.
module zt_burst_sram_tb_top;

    localparam int AW    = 6;
    localparam int NB    = 2;
    localparam int BW    = 9;
    localparam int DW    = NB * BW;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n, clk_en, sel0_n, sel1, sel2_n, load_n, we_n;
    logic [NB-1:0] byte_we_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] din, dout;
    logic          dout_oe, oe_n, sleep, flow_n, seq_ilv;

    always #2 clk = ~clk;

    zt_burst_sram #(.ADDR_W(AW), .NBYTES(NB), .BYTE_W(BW)) dut_i (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .sel0_n(sel0_n), .sel1(sel1),
        .sel2_n(sel2_n), .load_n(load_n), .we_n(we_n), .byte_we_n(byte_we_n),
        .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe), .oe_n(oe_n),
        .sleep(sleep), .flow_n(flow_n), .seq_ilv(seq_ilv)
    );

    int checks = 0;
    int failures = 0;

    logic [DW-1:0] ref_mem [DEPTH];
    bit            w_v [2];
    logic [AW-1:0] w_a [2];
    logic [NB-1:0] w_be [2];
    logic [DW-1:0] w_d [2];
    int            m_op, p_op, serial;
    logic [AW-1:0] m_base, m_addr, p_addr;
    logic [1:0]    m_beat;
    bit            out_v, md_flow, md_ilv;
    logic [DW-1:0] out_d;

    task automatic report(string tag, logic [DW:0] act, logic [DW:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual oe/data=%0d/%h expected %0d/%h at %0t",
                     tag, act[DW], act[DW-1:0], exp[DW], exp[DW-1:0], $time);
        end
    endtask

    task automatic clear_model();
        for (int i = 0; i < 2; i++) w_v[i] = 0;
        m_op = 0; p_op = 0; m_base = '0; m_beat = '0; m_addr = '0; p_addr = '0;
        out_v = 0;
    endtask

    // One clock: drive pins, step the model on enabled edges, then compare.
    task automatic tick(string tag, bit hold, bit slp, bit oen, bit ld_n, bit wr,
                        int desel, logic [AW-1:0] a, logic [NB-1:0] ben);
        bit en;
        bit exp_oe;
        int idx;
        @(negedge clk);
        en        = !hold && !slp;
        clk_en    = !hold;
        sleep     = slp;
        oe_n      = oen;
        load_n    = ld_n;
        we_n      = !wr;
        sel0_n    = (desel == 1);
        sel1      = (desel != 2);
        sel2_n    = (desel == 3);
        addr      = a;
        byte_we_n = ben;
        din       = (en && w_v[0]) ? w_d[0] : (DW'(18'h15A5A) ^ DW'(serial * 3));
        @(posedge clk);
        if (en) begin
            if (w_v[0])
                for (int b = 0; b < NB; b++)
                    if (w_be[0][b]) ref_mem[w_a[0]][b*BW +: BW] = w_d[0][b*BW +: BW];
            w_v[0] = w_v[1]; w_a[0] = w_a[1]; w_be[0] = w_be[1]; w_d[0] = w_d[1];
            w_v[1] = 0;
            if (!ld_n) begin
                m_base = a; m_beat = 2'd0;
                m_op = (desel != 0) ? 0 : (wr ? 2 : 1);
            end else begin
                m_beat = m_beat + 2'd1;
            end
            m_addr = {m_base[AW-1:2], md_ilv ? (m_base[1:0] ^ m_beat) : (m_base[1:0] + m_beat)};
            if (md_flow) begin
                out_v = (m_op == 1);
                if (out_v) out_d = ref_mem[m_addr];
            end else begin
                out_v = (p_op == 1);
                if (out_v) out_d = ref_mem[p_addr];
            end
            p_op = m_op; p_addr = m_addr;
            if (m_op == 2) begin
                serial++;
                idx = md_flow ? 0 : 1;
                w_v[idx] = 1; w_a[idx] = m_addr; w_be[idx] = ~ben;
                w_d[idx] = DW'(m_addr * 1237 + serial * 4099 + 5);
            end
        end
        #1;
        exp_oe = out_v && !oen && !slp;
        report(tag, {dout_oe, dout}, {exp_oe, exp_oe ? out_d : DW'(0)});
    endtask

    task automatic cmd(string tag, bit ld_n, bit wr, logic [AW-1:0] a, logic [NB-1:0] ben);
        tick(tag, 0, 0, 0, ld_n, wr, 0, a, ben);
    endtask

    task automatic idle(string tag);
        tick(tag, 0, 0, 0, 0, 0, 1, '0, '1);
    endtask

    task automatic do_reset(bit f, bit i);
        @(negedge clk);
        rst_n = 0; clk_en = 1; sleep = 0; oe_n = 0; load_n = 0; we_n = 1;
        sel0_n = 1; sel1 = 1; sel2_n = 1; addr = '0; byte_we_n = '1; din = '0;
        flow_n = !f; seq_ilv = i;
        md_flow = f; md_ilv = i;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        clear_model();
        #1;
        report("R1", {dout_oe, dout}, {1'b0, DW'(0)});
    endtask

    initial begin
        #800000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        string tl, tr, tb;
        serial = 0;
        for (int f = 0; f < 2; f++) begin
            for (int il = 0; il < 2; il++) begin
                do_reset(f[0], il[0]);
                tl = md_flow ? "R5" : "R4";
                tr = md_flow ? "R3" : "R2";
                tb = md_ilv ? "R10" : "R9";
                // Fill the array with write bursts starting at every offset.
                for (int g = 0; g < 16; g++) begin
                    cmd(tl, 0, 1, AW'(g * 4 + (g % 4)), '0);
                    for (int k = 1; k < 4; k++) cmd(tl, 1, 1, '0, '0);
                end
                idle("R14"); idle("R14");
                // Read bursts with a fifth wrapping beat.
                for (int g = 0; g < 16; g++) begin
                    cmd(tr, 0, 0, AW'(g * 4 + ((g + 1) % 4)), '1);
                    for (int k = 1; k < 5; k++) cmd(tb, 1, 0, '0, '1);
                end
                idle(tr); idle(tr);
                // Write then read the same address on the next cycle.
                for (int i = 0; i < 16; i++) begin
                    cmd("R6", 0, 1, AW'(i * 7), NB'(i % 4));
                    cmd("R6", 0, 0, AW'(i * 7), '1);
                end
                idle("R6"); idle("R6");
                // Every byte-enable pattern.
                for (int be = 0; be < 4; be++) begin
                    cmd("R7", 0, 1, AW'(5), NB'(be));
                    idle("R7"); idle("R7");
                    cmd("R7", 0, 0, AW'(5), '1);
                    idle("R7"); idle("R7");
                end
                // Each chip enable deasserted in turn.
                for (int d = 1; d < 4; d++) begin
                    tick("R8", 0, 0, 0, 0, 1, d, AW'(9), '0);
                    idle("R8"); idle("R8");
                    cmd("R8", 0, 0, AW'(9), '1);
                    idle("R8"); idle("R8");
                    tick("R8", 0, 0, 0, 0, 0, d, AW'(9), '1);
                    idle("R8"); idle("R8");
                end
                // Holds while write data is due, with a write command on the pins.
                cmd("R11", 0, 1, AW'(12), '0);
                for (int h = 0; h < 3; h++) tick("R11", 1, 0, 0, 0, 1, 0, AW'(13), '0);
                idle("R14"); idle("R14");
                cmd("R11", 0, 0, AW'(12), '1);
                idle("R11");
                for (int h = 0; h < 2; h++) tick("R11", 1, 0, 0, 0, 0, 0, AW'(13), '1);
                idle("R11"); idle("R11");
                cmd("R11", 0, 0, AW'(13), '1);
                idle("R11"); idle("R11");
                // Output enable override.
                cmd("R12", 0, 0, AW'(12), '1);
                tick("R12", 0, 0, 1, 1, 0, 0, '0, '1);
                tick("R12", 0, 0, 1, 1, 0, 0, '0, '1);
                tick("R12", 0, 0, 0, 1, 0, 0, '0, '1);
                idle("R12"); idle("R12");
                // Sleep with a write attempt on the pins.
                cmd("R13", 0, 0, AW'(12), '1);
                tick("R13", 0, 1, 0, 0, 1, 0, AW'(20), '0);
                tick("R13", 0, 1, 0, 0, 1, 0, AW'(20), '0);
                idle("R13"); idle("R13");
                cmd("R13", 0, 0, AW'(20), '1);
                idle("R13"); idle("R13");
            end
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule